// File: doc/BRIEF.md
# Multi-Channel DAC Card Update Controller

This block sits between an 8-bit processor write port and a card of N double-buffered 12-bit DAC channels. Each processor write is decoded from its 16-bit address. A write to a channel becomes a timed chip-select and write-strobe sequence on the shared control lines, with address bit 0 passed straight through as the byte-select. A write to the transfer register becomes a group transfer pulse. Each bit of the transfer word drives one channel's active-low transfer line, so any subset of channels changes its output in the same clock cycle. New data can be loaded into every channel ahead of time without disturbing the analog outputs.

The channels are included as simple behavioural models: an 8-bit high latch, a 4-bit low latch and a 12-bit output register. Their codes come out on `chan_code`. The strobe widths are derived from nanosecond minimums and the clock period, so the required pulse width and data hold are met at any clock rate.

A sequencer state machine does the sequencing. Its states are IDLE, STROBE (chip-select and write strobe low), HOLD (write strobe high, chip-select and data still held) and XFER (transfer lines driven from the latched word). It has five transitions:
- LOAD: IDLE to STROBE, taken on a decoded channel write.
- RELEASE: STROBE to HOLD, taken when the strobe count expires.
- DONE: HOLD to IDLE, taken when the hold count expires.
- FIRE: IDLE to XFER, taken on a transfer-register write.
- END: XFER to IDLE, taken when the transfer count expires.

Top module: `dac_card_ctrl`

## Requirements
- R1: After reset, every `dac_cs_n` bit, `dac_wr_n` and every `dac_xfer_n` bit are high, and every channel code is 0.
- R2: Channel c answers at address CH_BASE + 4c + 1 (first byte) and CH_BASE + 4c + 2 (second byte). During its sequence, only bit c of `dac_cs_n` is low, `dac_byte_hi` equals address bit 0 (1 for the first byte, 0 for the second), and `dac_data` equals the written byte.
- R3: For a channel write, `dac_wr_n` is low for exactly ceil(WR_MIN_NS/CLK_NS) consecutive cycles, and the channel's chip-select stays low throughout.
- R4: After `dac_wr_n` rises, chip-select, `dac_byte_hi` and `dac_data` stay unchanged for exactly ceil(HOLD_MIN_NS/CLK_NS) more cycles. Then all chip-selects go high.
- R5: A first-byte write loads the channel's upper 8 code bits from data[7:0] and its lower 4 bits from data[7:4]. A second-byte write replaces only the lower 4 bits with data[7:4]. Bits [3:0] of a second-byte write are ignored.
- R6: Loading data into a channel leaves its output code unchanged until a transfer selects that channel.
- R7: A write to XFER_ADDR drives `dac_xfer_n[c]` from data bit c for exactly XFER_CYC cycles. All channels written 0 go low in the same cycles. Data bits at N and above are ignored. Afterwards every transfer line is high again.
- R8: After a transfer, each channel whose word bit was 0 shows its latched 12-bit code, and each channel whose bit was 1 keeps its previous code.
- R9: A write to any other address, including offsets 0 and 3 of a channel block, drives no chip-select, write strobe or transfer line and changes no code.
- R10: A write is taken on the falling edge of `bus_wr_n`. A falling edge that arrives while a sequence is in progress is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Processor write address |
| bus_data | input | 8 | Processor write data |
| bus_wr_n | input | 1 | Active-low processor write strobe |
| dac_cs_n | output | N | Per-channel active-low chip-select |
| dac_byte_hi | output | 1 | Byte-select: 1 loads all 12 latch bits, 0 loads only the low 4 bits |
| dac_wr_n | output | 1 | Shared active-low input-latch write strobe |
| dac_xfer_n | output | N | Per-channel active-low transfer strobe |
| dac_data | output | 8 | Shared data bus to the channels |
| chan_code | output | 12*N | Output register of each channel model, channel c at bits [12c+11:12c] |

## Verification
On every cycle, the assertions check the following:
- At most one chip-select is low.
- No transfer line is low while a chip-select or the write strobe is active.
- The write strobe, the hold window and the transfer pulse each last exactly their derived cycle counts.
- The chip-select data stays stable.
- A channel's code never moves unless its transfer line is low.

Only the bench scenarios can show the following:
- That the right channel and byte are chosen for each address.
- The left-justified byte packing.
- That every one of the sixteen transfer subsets updates exactly the selected channels.
- That undecoded writes and writes arriving while busy leave all latched data untouched.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_HOLD,
        ST_XFER
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dcc_addr_decode.sv
module dcc_addr_decode #(
    parameter int          N         = 8,
    parameter logic [15:0] CH_BASE   = 16'h4000,
    parameter logic [15:0] XFER_ADDR = 16'h4100
) (
    input  logic [15:0]  addr,
    output logic [N-1:0] ch_hit,
    output logic         xfer_hit
);
    localparam logic [13:0] BASE_BLK = CH_BASE[15:2];

    // Only offsets 1 (first byte) and 2 (second byte) of a block are decoded.
    logic byte_slot;
    assign byte_slot = addr[1] ^ addr[0];

    for (genvar c = 0; c < N; c++) begin : g_blk
        localparam logic [13:0] BLK = BASE_BLK + 14'(c);
        assign ch_hit[c] = byte_slot && (addr[15:2] == BLK);
    end

    assign xfer_hit = (addr == XFER_ADDR);

endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
    import dcc_pkg::*;
#(
    parameter int N          = 8,
    parameter int DW         = 8,
    parameter int STROBE_CYC = 32,
    parameter int HOLD_CYC   = 9,
    parameter int XFER_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  ch_hit,
    input  logic          xfer_hit,
    input  logic          a0,
    input  logic [DW-1:0] din,
    output logic [N-1:0]  cs_n,
    output logic          byte_hi,
    output logic          wr_n,
    output logic [N-1:0]  xfer_n,
    output logic [DW-1:0] dout
);
    localparam int CW = $clog2(max3(STROBE_CYC, HOLD_CYC, XFER_CYC) + 1);

    seq_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            load, fire;
    logic [N-1:0]    sel_q;
    logic [N-1:0]    word_q;
    logic            a0_q;
    logic [DW-1:0]   data_q;

    // Next state: transitions LOAD, FIRE, RELEASE, DONE, END
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (|ch_hit)) begin
                    state_d = ST_STROBE;
                    cnt_d   = CW'(STROBE_CYC - 1);
                    load    = 1'b1;
                end else if (start && xfer_hit) begin
                    state_d = ST_XFER;
                    cnt_d   = CW'(XFER_CYC - 1);
                    fire    = 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_q == '0) begin
                    state_d = ST_HOLD;
                    cnt_d   = CW'(HOLD_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_XFER: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
            word_q  <= '1;
            a0_q    <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                sel_q  <= ch_hit;
                a0_q   <= a0;
                data_q <= din;
            end
            if (fire) word_q <= din[N-1:0];
        end
    end

    // Outputs
    always_comb begin
        cs_n   = '1;
        wr_n   = 1'b1;
        xfer_n = '1;
        unique case (state_q)
            ST_IDLE:   ;
            ST_STROBE: begin
                cs_n = ~sel_q;
                wr_n = 1'b0;
            end
            ST_HOLD:   cs_n = ~sel_q;
            ST_XFER:   xfer_n = word_q;
            default:   ;
        endcase
    end

    assign byte_hi = a0_q;
    assign dout    = data_q;

    // Window counters used only by the checks below
    logic [CW-1:0] lo_run, hold_run, xf_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run   <= '0;
            hold_run <= '0;
            xf_run   <= '0;
        end else begin
            lo_run   <= (!wr_n) ? lo_run + 1'b1 : '0;
            hold_run <= (wr_n && !(&cs_n)) ? hold_run + 1'b1 : '0;
            xf_run   <= (!(&xfer_n)) ? xf_run + 1'b1 : '0;
        end
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R2
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (lo_run == CW'(STROBE_CYC))); // R3
    AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ($countones(~cs_n) == 1)); // R3
    AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> (hold_run == CW'(HOLD_CYC))); // R4
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && $past(!(&cs_n))) |-> ($stable(dout) && $stable(byte_hi))); // R4
    AST_XFER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&xfer_n) |-> (xf_run == CW'(XFER_CYC))); // R7
    AST_XFER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(&xfer_n) |-> ((&cs_n) && wr_n)); // R7

endmodule

// File: rtl/dcc_chan_model.sv
module dcc_chan_model #(
    parameter int DW  = 8,
    parameter int RES = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           wr1_n,
    input  logic           byte_hi,
    input  logic           wr2_n,
    input  logic           xfer_n,
    input  logic [DW-1:0]  din,
    output logic [RES-1:0] code
);
    localparam int LO = RES - DW;

    logic [DW-1:0] hi_q;
    logic [LO-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            code <= '0;
        end else begin
            if (!cs_n && !wr1_n) begin
                if (byte_hi) hi_q <= din;
                lo_q <= din[DW-1 -: LO];
            end
            if (!wr2_n && !xfer_n) code <= {hi_q, lo_q};
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_n |=> $stable(code)); // R6

endmodule

// File: rtl/dac_card_ctrl.sv
module dac_card_ctrl
    import dcc_pkg::*;
#(
    parameter int          N           = 8,
    parameter logic [15:0] CH_BASE     = 16'h4000,
    parameter logic [15:0] XFER_ADDR   = 16'h4100,
    parameter int          CLK_NS      = 10,
    parameter int          WR_MIN_NS   = 320,
    parameter int          HOLD_MIN_NS = 90,
    parameter int          XFER_CYC    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     bus_addr,
    input  logic [7:0]      bus_data,
    input  logic            bus_wr_n,
    output logic [N-1:0]    dac_cs_n,
    output logic            dac_byte_hi,
    output logic            dac_wr_n,
    output logic [N-1:0]    dac_xfer_n,
    output logic [7:0]      dac_data,
    output logic [12*N-1:0] chan_code
);
    localparam int DW         = 8;
    localparam int RES        = 12;
    localparam int STROBE_CYC = ceil_div(WR_MIN_NS, CLK_NS);
    localparam int HOLD_CYC   = ceil_div(HOLD_MIN_NS, CLK_NS);

    logic         wr_q;
    logic         start;
    logic [N-1:0] ch_hit;
    logic         xfer_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= bus_wr_n;
    end
    assign start = wr_q && !bus_wr_n;

    dcc_addr_decode #(.N(N), .CH_BASE(CH_BASE), .XFER_ADDR(XFER_ADDR)) u_dec (
        .addr     (bus_addr),
        .ch_hit   (ch_hit),
        .xfer_hit (xfer_hit)
    );

    dcc_seq #(
        .N(N), .DW(DW), .STROBE_CYC(STROBE_CYC),
        .HOLD_CYC(HOLD_CYC), .XFER_CYC(XFER_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ch_hit   (ch_hit),
        .xfer_hit (xfer_hit),
        .a0       (bus_addr[0]),
        .din      (bus_data),
        .cs_n     (dac_cs_n),
        .byte_hi  (dac_byte_hi),
        .wr_n     (dac_wr_n),
        .xfer_n   (dac_xfer_n),
        .dout     (dac_data)
    );

    for (genvar c = 0; c < N; c++) begin : g_ch
        dcc_chan_model #(.DW(DW), .RES(RES)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cs_n    (dac_cs_n[c]),
            .wr1_n   (dac_wr_n),
            .byte_hi (dac_byte_hi),
            .wr2_n   (1'b0),
            .xfer_n  (dac_xfer_n[c]),
            .din     (dac_data),
            .code    (chan_code[c*RES +: RES])
        );
    end

endmodule

// File: tb/sim_dac_card_ctrl.sv
`timescale 1ns/1ps
module sim_dac_card_ctrl;
    localparam int N  = 4;
    localparam int XC = 3;
    localparam int EXP_WR   = (320 + 10 - 1) / 10;
    localparam int EXP_HOLD = (90 + 10 - 1) / 10;
    localparam logic [15:0] BASE = 16'h4000;
    localparam logic [15:0] XADR = 16'h4100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_wr_n = 1'b1;
    logic [N-1:0] dac_cs_n, dac_xfer_n;
    logic dac_byte_hi, dac_wr_n;
    logic [7:0] dac_data;
    logic [12*N-1:0] chan_code;

    int checks = 0, errors = 0;
    logic [7:0]  p_hi [N];
    logic [3:0]  p_lo [N];
    logic [11:0] cur  [N];

    always #5 clk = ~clk;

    dac_card_ctrl #(.N(N), .CH_BASE(BASE), .XFER_ADDR(XADR), .CLK_NS(10),
        .WR_MIN_NS(320), .HOLD_MIN_NS(90), .XFER_CYC(XC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_wr_n(bus_wr_n), .dac_cs_n(dac_cs_n), .dac_byte_hi(dac_byte_hi),
        .dac_wr_n(dac_wr_n), .dac_xfer_n(dac_xfer_n), .dac_data(dac_data),
        .chan_code(chan_code));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_codes(input string tag);
        for (int c = 0; c < N; c++)
            chk(chan_code[c*12 +: 12] == cur[c], tag, int'(chan_code[c*12 +: 12]), int'(cur[c]));
    endtask

    // One bus write; ch<0 means no channel may respond
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input int ch,
                             input bit intr, input logic [15:0] a2, input logic [7:0] d2);
        int lo = 0, hold = 0, bad = 0;
        bit seen = 0;
        logic [N-1:0] m;
        m = (ch >= 0) ? N'(1) << ch : '0;
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_wr_n = 1'b0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (i == 1) bus_wr_n = 1'b1;
            if (intr && i == 4) begin bus_addr = a2; bus_data = d2; bus_wr_n = 1'b0; end
            if (intr && i == 6) bus_wr_n = 1'b1;
            if (!dac_wr_n) begin lo++; seen = 1; end
            else if (seen && dac_cs_n != '1) hold++;
            if (dac_cs_n != '1) begin
                if (ch < 0 || dac_cs_n != ~m || dac_byte_hi != a[0] || dac_data != d) bad++;
            end
            if (dac_xfer_n != '1) bad++;
        end
        if (ch >= 0) begin
            chk(lo == EXP_WR, "R3 strobe width", lo, EXP_WR);
            chk(hold == EXP_HOLD, "R4 hold window", hold, EXP_HOLD);
            chk(bad == 0, "R2 select/byte/data", bad, 0);
            if (a[0]) begin p_hi[ch] = d; p_lo[ch] = d[7:4]; end
            else      p_lo[ch] = d[7:4];
        end else begin
            chk(lo == 0 && bad == 0, "R9 undecoded write quiet", lo + bad, 0);
        end
    endtask

    task automatic xfer(input logic [7:0] w);
        int cnt [N];
        int bad = 0;
        for (int c = 0; c < N; c++) cnt[c] = 0;
        @(negedge clk);
        bus_addr = XADR; bus_data = w; bus_wr_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 1) bus_wr_n = 1'b1;
            if (dac_xfer_n != '1 && dac_xfer_n != w[N-1:0]) bad++;
            for (int c = 0; c < N; c++) if (!dac_xfer_n[c]) cnt[c]++;
        end
        chk(bad == 0, "R7 simultaneous pattern", bad, 0);
        for (int c = 0; c < N; c++) begin
            chk(cnt[c] == (w[c] ? 0 : XC), "R7 transfer pulse width", cnt[c], w[c] ? 0 : XC);
            if (!w[c]) cur[c] = {p_hi[c], p_lo[c]};
        end
        chk(dac_xfer_n == '1, "R7 lines released", int'(dac_xfer_n), (1 << N) - 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin p_hi[c] = '0; p_lo[c] = '0; cur[c] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dac_cs_n == '1 && dac_wr_n && dac_xfer_n == '1, "R1 control lines idle",
            int'({dac_cs_n, dac_wr_n, dac_xfer_n}), (1 << (2*N + 1)) - 1);
        check_codes("R1 codes zero");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 first byte alone fills low nibble from data[7:4]
        bus_write(BASE + 16'd1, 8'hA5, 0, 0, '0, '0);
        check_codes("R6 no change before transfer");
        xfer(8'hFE);
        chk(chan_code[11:0] == 12'hA5A, "R5 first byte fills both latches",
            int'(chan_code[11:0]), 12'hA5A);
        // R5 second byte replaces only the low nibble; data[3:0] ignored
        bus_write(BASE + 16'd2, 8'h3F, 0, 0, '0, '0);
        xfer(8'hFE);
        chk(chan_code[11:0] == 12'hA53, "R5 second byte low nibble only",
            int'(chan_code[11:0]), 12'hA53);

        // R8 sweep of every transfer subset
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < N; c++) begin
                logic [11:0] v;
                v = 12'((s * 'h1F3 + c * 'h29B + 'h111) & 'hFFF);
                bus_write(BASE + 16'(4*c) + 16'd1, v[11:4], c, 0, '0, '0);
                bus_write(BASE + 16'(4*c) + 16'd2, {v[3:0], 4'(s)}, c, 0, '0, '0);
            end
            check_codes("R6 loaded data held back");
            xfer({4'(s) ^ 4'h9, ~4'(s)}); // R7 upper bits are junk
            check_codes("R8 subset update");
        end

        // R9 undecoded addresses
        bus_write(BASE + 16'd3, 8'h11, -1, 0, '0, '0);
        bus_write(BASE + 16'd4, 8'h22, -1, 0, '0, '0);
        bus_write(BASE + 16'h0011, 8'h33, -1, 0, '0, '0);
        bus_write(XADR + 16'd1, 8'h00, -1, 0, '0, '0);
        check_codes("R9 no output change");
        xfer(8'hFF);
        check_codes("R7 all-ones word updates none");
        xfer(8'hF0);
        check_codes("R9 latches untouched by undecoded writes");

        // R10 write arriving during a sequence is dropped
        bus_write(BASE + 16'd5, 8'h3C, 1, 1, BASE + 16'd9, 8'hC3);
        xfer(8'h00);
        check_codes("R10 busy write ignored");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule